// File: doc/BRIEF.md
# Packet DRAM Bank Timing Monitor

This block watches the decoded row and column command packets sent to one packet-based DRAM device with 32 banks. It checks every minimum and maximum spacing rule between those commands. Timing is counted in interface clock cycles. Per-bank rules cover activate, precharge, column access and retire. Device-wide rules cover successive activates, successive precharges and successive column packets. The block also tracks whether each bank is open or closed, and it reports a command that does not fit that state.

The monitor sits beside a memory controller, on the same decoded command stream that goes to the device. It drives no device signals. When it sees the first violation it raises a flag and records a code that identifies the broken rule. Both stay unchanged until a synchronous reset. Every interval is a module parameter, so one monitor can serve several speed grades.

Top module: `bank_timing_mon`

## Requirements
- R1: Each of the 32 banks is tracked as open or closed. The row opcode is 0 for activate and 1 for precharge. The column opcode is 0 for read, 1 for write, 2 for retire and 3 for column precharge. A read, write or retire to a closed bank gives code 12. An activate to an open bank gives code 13.
- R2: Two activates to the same bank closer than RC_CYC cycles (default 28) give code 1.
- R3: A precharge (row or column) to a bank fewer than RAS_CYC cycles (default 20) after that bank's activate gives code 2.
- R4: A bank that stays open for more than RAS_MAX_CYC cycles without a precharge gives code 3. The fault is raised in the cycle that lies RAS_MAX_CYC+1 cycles after the activate. A precharge at exactly RAS_MAX_CYC cycles is legal.
- R5: An activate fewer than RP_CYC cycles (default 8) after a precharge to the same bank gives code 4. A column precharge closes the bank and starts this interval just as a row precharge does.
- R6: Two row precharges to any banks closer than PP_CYC cycles (default 8) give code 5. Two activates to any banks closer than RR_CYC cycles (default 8) give code 6.
- R7: A read or write fewer than RCD_CYC cycles (default 7) after the activate of its bank gives code 7.
- R8: Two column commands to any banks closer than CC_CYC cycles (default 4) give code 8.
- R9: A retire fewer than RTR_CYC cycles (default 8) after the last write to its bank gives code 9.
- R10: A precharge fewer than RDP_CYC cycles (default 4) after the last read to its bank gives code 10. A precharge fewer than RTP_CYC cycles (default 4) after the last retire to its bank gives code 11.
- R11: An interval is the number of clock edges between the edges that sample the two commands. An interval equal to its minimum is legal.
- R12: After reset, err_flag is 0 and err_code is 0. On the first violation, err_flag rises and err_code takes the code, both visible right after the edge that samples the offending command. If several violations occur in that cycle, the lowest code is kept. Both values then hold until a synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; one cycle is one time unit |
| rst | input | 1 | Synchronous reset, active high |
| row_vld | input | 1 | Row command packet present this cycle |
| row_op | input | 1 | Row opcode: 0 activate, 1 precharge |
| row_bank | input | 5 | Bank addressed by the row command |
| col_vld | input | 1 | Column command packet present this cycle |
| col_op | input | 2 | Column opcode: 0 read, 1 write, 2 retire, 3 precharge |
| col_bank | input | 5 | Bank addressed by the column command |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation, 0 when none |

## Verification
The maximum open-time fault is the hardest case to reach from the ports. At the production value the bank would have to be held open for tens of thousands of cycles. The bench lowers RAS_MAX_CYC to 100 and walks both sides of that limit. It also raises RC_CYC above RAS_CYC + RP_CYC, because with the default values the same-bank activate spacing cannot fail on its own. A case with a row and a column violation in the same cycle checks the lowest-code priority.

// File: rtl/bt_pkg.sv
package bt_pkg;
   localparam int NCODE = 14;
   localparam int CW    = 4;

   // violation codes (bit index in the violation vectors)
   localparam int V_RC      = 1;
   localparam int V_RAS     = 2;
   localparam int V_RASMAX  = 3;
   localparam int V_RP      = 4;
   localparam int V_PP      = 5;
   localparam int V_RR      = 6;
   localparam int V_RCD     = 7;
   localparam int V_CC      = 8;
   localparam int V_RTR     = 9;
   localparam int V_RDP     = 10;
   localparam int V_RTP     = 11;
   localparam int V_CLOSED  = 12;
   localparam int V_REOPEN  = 13;

   localparam logic       ROW_ACT = 1'b0;
   localparam logic       ROW_PRE = 1'b1;
   localparam logic [1:0] COL_RD  = 2'd0;
   localparam logic [1:0] COL_WR  = 2'd1;
   localparam logic [1:0] COL_RET = 2'd2;
   localparam logic [1:0] COL_PRE = 2'd3;
endpackage

// File: rtl/bt_dncnt.sv
module bt_dncnt #(
   parameter int unsigned SPAN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   output logic busy_o
);
   localparam int unsigned START = (SPAN > 0) ? SPAN - 1 : 0;
   localparam int          W     = (START < 2) ? 1 : $clog2(START + 1);

   generate
      if (SPAN < 1) begin : g_bad_span
         $error("bt_dncnt: SPAN must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= W'(START);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   generate
      if (START > 0) begin : g_chk
         // R11
         span_load_chk: assert property (@(posedge clk) disable iff (rst)
            load_i |=> busy_o);
      end
   endgenerate
endmodule

// File: rtl/bt_bank.sv
module bt_bank
   import bt_pkg::*;
#(
   parameter int unsigned RC_CYC      = 28,
   parameter int unsigned RAS_CYC     = 20,
   parameter int unsigned RAS_MAX_CYC = 25600,
   parameter int unsigned RP_CYC      = 8,
   parameter int unsigned RCD_CYC     = 7,
   parameter int unsigned RTR_CYC     = 8,
   parameter int unsigned RDP_CYC     = 4,
   parameter int unsigned RTP_CYC     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_i,
   input  logic             rpre_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic             ret_i,
   input  logic             cpre_i,
   output logic [NCODE-1:0] viol_o
);
   localparam int MW = $clog2(RAS_MAX_CYC + 1);

   generate
      if (RAS_MAX_CYC < RAS_CYC) begin : g_bad_max
         $error("bt_bank: RAS_MAX_CYC below RAS_CYC");
      end
   endgenerate

   logic pre;
   logic open_q;
   logic rc_b, ras_b, rp_b, rcd_b, rtr_b, rdp_b, rtp_b;
   logic [MW-1:0] live_q;

   assign pre = rpre_i | cpre_i;

   bt_dncnt #(.SPAN(RC_CYC))  u_rc  (.clk(clk), .rst(rst), .load_i(act_i), .busy_o(rc_b));
   bt_dncnt #(.SPAN(RAS_CYC)) u_ras (.clk(clk), .rst(rst), .load_i(act_i), .busy_o(ras_b));
   bt_dncnt #(.SPAN(RP_CYC))  u_rp  (.clk(clk), .rst(rst), .load_i(pre),   .busy_o(rp_b));
   bt_dncnt #(.SPAN(RCD_CYC)) u_rcd (.clk(clk), .rst(rst), .load_i(act_i), .busy_o(rcd_b));
   bt_dncnt #(.SPAN(RTR_CYC)) u_rtr (.clk(clk), .rst(rst), .load_i(wr_i),  .busy_o(rtr_b));
   bt_dncnt #(.SPAN(RDP_CYC)) u_rdp (.clk(clk), .rst(rst), .load_i(rd_i),  .busy_o(rdp_b));
   bt_dncnt #(.SPAN(RTP_CYC)) u_rtp (.clk(clk), .rst(rst), .load_i(ret_i), .busy_o(rtp_b));

   // open/closed state; an activate outranks a same-cycle column precharge
   always_ff @(posedge clk) begin
      if (rst)
         open_q <= 1'b0;
      else if (act_i)
         open_q <= 1'b1;
      else if (pre)
         open_q <= 1'b0;
   end

   // open-time budget, counts down while the bank is open
   always_ff @(posedge clk) begin
      if (rst)
         live_q <= '0;
      else if (act_i)
         live_q <= MW'(RAS_MAX_CYC);
      else if (open_q && live_q != '0)
         live_q <= live_q - 1'b1;
   end

   always_comb begin
      viol_o           = '0;
      viol_o[V_RC]     = act_i & rc_b;
      viol_o[V_RAS]    = pre & ras_b;
      viol_o[V_RASMAX] = open_q & (live_q == '0) & ~pre & ~act_i;
      viol_o[V_RP]     = act_i & rp_b;
      viol_o[V_RCD]    = (rd_i | wr_i) & rcd_b;
      viol_o[V_RTR]    = ret_i & rtr_b;
      viol_o[V_RDP]    = pre & rdp_b;
      viol_o[V_RTP]    = pre & rtp_b;
      viol_o[V_CLOSED] = (rd_i | wr_i | ret_i) & ~open_q;
      viol_o[V_REOPEN] = act_i & open_q;
   end

   // R1
   open_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(open_q) |-> $past(act_i));

   // R1
   close_src_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(open_q) |-> $past(pre));
endmodule

// File: rtl/bank_timing_mon.sv
module bank_timing_mon
   import bt_pkg::*;
#(
   parameter int unsigned BANKS       = 32,
   parameter int unsigned RC_CYC      = 28,
   parameter int unsigned RAS_CYC     = 20,
   parameter int unsigned RAS_MAX_CYC = 25600,
   parameter int unsigned RP_CYC      = 8,
   parameter int unsigned PP_CYC      = 8,
   parameter int unsigned RR_CYC      = 8,
   parameter int unsigned RCD_CYC     = 7,
   parameter int unsigned CC_CYC      = 4,
   parameter int unsigned RTR_CYC     = 8,
   parameter int unsigned RDP_CYC     = 4,
   parameter int unsigned RTP_CYC     = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     row_vld,
   input  logic                     row_op,
   input  logic [$clog2(BANKS)-1:0] row_bank,
   input  logic                     col_vld,
   input  logic [1:0]               col_op,
   input  logic [$clog2(BANKS)-1:0] col_bank,
   output logic                     err_flag,
   output logic [CW-1:0]            err_code
);
   localparam int BW = $clog2(BANKS);

   generate
      if (BANKS < 2 || (1 << BW) != BANKS) begin : g_bad_banks
         $error("bank_timing_mon: BANKS must be a power of two, at least 2");
      end
   endgenerate

   logic             row_act, row_pre;
   logic             pp_b, rr_b, cc_b;
   logic [NCODE-1:0] bank_viol [BANKS];
   logic [NCODE-1:0] all_viol;
   logic             any_viol;
   logic [CW-1:0]    first_code;

   assign row_act = row_vld & (row_op == ROW_ACT);
   assign row_pre = row_vld & (row_op == ROW_PRE);

   // device-wide spacing timers
   bt_dncnt #(.SPAN(PP_CYC)) u_pp (.clk(clk), .rst(rst), .load_i(row_pre), .busy_o(pp_b));
   bt_dncnt #(.SPAN(RR_CYC)) u_rr (.clk(clk), .rst(rst), .load_i(row_act), .busy_o(rr_b));
   bt_dncnt #(.SPAN(CC_CYC)) u_cc (.clk(clk), .rst(rst), .load_i(col_vld), .busy_o(cc_b));

   // one tracker per bank
   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic rhit, chit;
         assign rhit = row_vld & (row_bank == BW'(b));
         assign chit = col_vld & (col_bank == BW'(b));

         bt_bank #(
            .RC_CYC(RC_CYC), .RAS_CYC(RAS_CYC), .RAS_MAX_CYC(RAS_MAX_CYC),
            .RP_CYC(RP_CYC), .RCD_CYC(RCD_CYC), .RTR_CYC(RTR_CYC),
            .RDP_CYC(RDP_CYC), .RTP_CYC(RTP_CYC)
         ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .act_i  (rhit & (row_op == ROW_ACT)),
            .rpre_i (rhit & (row_op == ROW_PRE)),
            .rd_i   (chit & (col_op == COL_RD)),
            .wr_i   (chit & (col_op == COL_WR)),
            .ret_i  (chit & (col_op == COL_RET)),
            .cpre_i (chit & (col_op == COL_PRE)),
            .viol_o (bank_viol[b])
         );
      end
   endgenerate

   always_comb begin
      all_viol = '0;
      for (int b = 0; b < int'(BANKS); b++)
         all_viol = all_viol | bank_viol[b];
      all_viol[V_PP] = all_viol[V_PP] | (row_pre & pp_b);
      all_viol[V_RR] = all_viol[V_RR] | (row_act & rr_b);
      all_viol[V_CC] = all_viol[V_CC] | (col_vld & cc_b);
   end

   assign any_viol = |all_viol;

   // lowest code wins among same-cycle violations
   always_comb begin
      first_code = '0;
      for (int i = NCODE - 1; i >= 1; i--)
         if (all_viol[i]) first_code = CW'(i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err_flag <= 1'b0;
         err_code <= '0;
      end else if (!err_flag && any_viol) begin
         err_flag <= 1'b1;
         err_code <= first_code;
      end
   end

   // R12
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      err_flag |=> err_flag);

   // R12
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      err_flag |=> $stable(err_code));

   // R12
   code_valid_chk: assert property (@(posedge clk) disable iff (rst)
      err_flag |-> (err_code != '0));

   generate
      if (CC_CYC >= 2) begin : g_cc_chk
         // R8
         col_burst_chk: assert property (@(posedge clk) disable iff (rst)
            (col_vld && $past(col_vld) && !$past(rst)) |=> err_flag);
      end
   endgenerate
endmodule

// File: tb/bank_timing_mon_test.sv
`timescale 1ns/1ps
module bank_timing_mon_test;
   localparam int RASMAX = 100;
   localparam int NV     = 19;
   localparam int NONE   = 7;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       row_vld = 1'b0;
   logic       row_op = 1'b0;
   logic [4:0] row_bank = '0;
   logic       col_vld = 1'b0;
   logic [1:0] col_op = '0;
   logic [4:0] col_bank = '0;
   logic       err_flag;
   logic [3:0] err_code;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   bank_timing_mon #(.RC_CYC(30), .RAS_MAX_CYC(RASMAX)) uut (
      .clk(clk), .rst(rst),
      .row_vld(row_vld), .row_op(row_op), .row_bank(row_bank),
      .col_vld(col_vld), .col_op(col_op), .col_bank(col_bank),
      .err_flag(err_flag), .err_code(err_code)
   );

   // ops: 0 act, 1 row pre, 2 rd, 3 wr, 4 retire, 5 col pre, 7 none
   // fields: preopen, opA, bankA, dB, opB, bankB, dC, opC, bankC, exp code, req
   localparam int VEC [NV][11] = '{
      '{0, 0, 3, 20, 1, 3, 10, 0, 3,  0,  2},  // R2 R11 spacing exactly met
      '{0, 0, 3, 20, 1, 3,  9, 0, 3,  1,  2},  // R2 one short
      '{0, 0, 5, 19, 1, 5,  0, 7, 0,  2,  3},  // R3
      '{0, 0, 5, 20, 1, 5,  0, 7, 0,  0,  3},  // R3 R11 boundary
      '{0, 0, 5, 23, 1, 5,  7, 0, 5,  4,  5},  // R5
      '{0, 1, 1,  7, 1, 2,  0, 7, 0,  5,  6},  // R6 precharge spacing
      '{0, 1, 1,  8, 1, 2,  0, 7, 0,  0,  6},  // R6 boundary
      '{0, 0, 1,  7, 0, 2,  0, 7, 0,  6,  6},  // R6 activate spacing
      '{0, 0, 4,  6, 2, 4,  0, 7, 0,  7,  7},  // R7
      '{0, 0, 4,  7, 3, 4,  0, 7, 0,  0,  7},  // R7 boundary
      '{1, 2, 4,  3, 2, 4,  0, 7, 0,  8,  8},  // R8
      '{1, 3, 4,  7, 4, 4,  0, 7, 0,  9,  9},  // R9
      '{1, 3, 4,  8, 4, 4,  0, 7, 0,  0,  9},  // R9 boundary
      '{1, 2, 4,  3, 1, 4,  0, 7, 0, 10, 10},  // R10 read to precharge
      '{1, 3, 4,  8, 4, 4,  3, 1, 4, 11, 10},  // R10 retire to precharge
      '{0, 2, 6,  0, 7, 0,  0, 7, 0, 12,  1},  // R1 read of closed bank
      '{1, 0, 4,  0, 7, 0,  0, 7, 0, 13,  1},  // R1 activate of open bank
      '{1, 5, 4,  7, 0, 4,  0, 7, 0,  4,  5},  // R5 column precharge starts interval
      '{1, 5, 4,  4, 2, 4,  0, 7, 0, 12,  1}   // R1 column precharge closes bank
   };

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input int op, input int bank);
      if (op <= 1) begin
         row_vld  = 1'b1;
         row_op   = op[0];
         row_bank = bank[4:0];
      end else begin
         col_vld  = 1'b1;
         col_op   = 2'(op - 2);
         col_bank = bank[4:0];
      end
      @(negedge clk);
      row_vld = 1'b0;
      col_vld = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
   endtask

   task automatic check(input int req, input logic ef, input int ec);
      n_chk++;
      if (err_flag !== ef || err_code !== 4'(ec)) begin
         n_bad++;
         $display("FAIL R%0d: flag=%0b code=%0d expected flag=%0b code=%0d",
                  req, err_flag, err_code, ef, ec);
      end
   endtask

   initial begin
      idle(1);
      do_reset();
      // R12 reset state
      check(12, 1'b0, 0);

      for (int v = 0; v < NV; v++) begin
         do_reset();
         if (VEC[v][0] != 0) begin
            drive(0, VEC[v][2]);
            idle(40);
         end
         drive(VEC[v][1], VEC[v][2]);
         if (VEC[v][4] != NONE) begin
            idle(VEC[v][3] - 1);
            drive(VEC[v][4], VEC[v][5]);
         end
         if (VEC[v][7] != NONE) begin
            idle(VEC[v][6] - 1);
            drive(VEC[v][7], VEC[v][8]);
         end
         check(VEC[v][10], VEC[v][9] != 0, VEC[v][9]);
      end

      // R12 same-cycle row and column faults: codes 6 and 12, lowest kept
      do_reset();
      drive(0, 0);
      row_vld = 1'b1; row_op = 1'b0; row_bank = 5'd1;
      col_vld = 1'b1; col_op = 2'd0; col_bank = 5'd2;
      @(negedge clk);
      row_vld = 1'b0; col_vld = 1'b0;
      check(12, 1'b1, 6);
      // R12 later fault does not overwrite the first code
      idle(10);
      drive(2, 3);
      check(12, 1'b1, 6);
      // R12 synchronous reset clears both outputs
      do_reset();
      check(12, 1'b0, 0);

      // R4 precharge at exactly the open-time limit is legal
      do_reset();
      drive(0, 9);
      idle(RASMAX - 1);
      drive(1, 9);
      check(4, 1'b0, 0);

      // R4 bank left open: quiet at the limit, fault one cycle later
      do_reset();
      drive(0, 9);
      idle(RASMAX);
      check(4, 1'b0, 0);
      idle(1);
      check(4, 1'b1, 3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R12: watchdog expired, actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule